// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block owns the row strobe, the column strobes and write enable of an asynchronous DRAM whenever the host access path is not using them. After reset it holds every strobe inactive through a startup pause. It then runs a fixed number of wake-up refresh cycles, in which the column strobes fall before the row strobe. When the last of these ends it raises `ready` and hands the bus to the access path through `grant`.

In normal operation an interval timer marks when a refresh is due. The sequencer issues one column-before-row refresh for each due point, but only while the access path is idle. Due points that arrive while the host holds the bus are counted in a small saturating counter and issued back to back once the host lets go.

A self-refresh request puts the device into self-refresh, with the row strobe held low for at least a minimum time. On exit the row strobe stays high for a recovery time. A full burst of row-only refreshes follows, addressed from an internal row counter. Write enable is never driven low, so refresh cycles cannot put the device into its test mode. All timings are parameters in clock cycles. The refresh interval is chosen between a normal rate and a low-power rate.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst` is high, `ras_n`, every bit of `cas_n` and `we_n` are 1, and `ready` and `grant` are 0.
- R2: After reset is released, all strobes stay high for exactly INIT_CYC cycles. Exactly WAKE_CNT column-before-row cycles then run before `ready` rises. `grant` is 0 until `ready` is 1, and `ready` never falls again before the next reset.
- R3: In every column-before-row cycle, all bits of `cas_n` switch together. They are low for exactly T_CSR cycles before `ras_n` falls and remain low while `ras_n` is low, which lasts exactly T_RAS cycles outside self-refresh. They rise in the same cycle as `ras_n`. Before each such fall, `ras_n` has been high for at least T_CSR+T_RP cycles.
- R4: `we_n` is 1 in every cycle.
- R5: With the host idle, successive periodic refresh falls of `ras_n` are exactly REFI cycles apart. REFI equals REFI_LP when LOW_POWER is 1, and REFI_NORM otherwise.
- R6: The host raises `host_busy` only while `grant` is 1. While `host_busy` is 1, no strobe is driven low. Whenever `grant` is 1, all strobes are high.
- R7: Each refresh that falls due while `host_busy` is high is issued after `host_busy` drops, back to back. The number issued is min(due points, 2^PEND_W-1).
- R8: A `self_req` seen while `grant` is 1 starts a column-before-row entry. `ras_n` then stays low for at least T_SELF cycles and for as long as `self_req` stays high.
- R9: After self-refresh exit, `ras_n` is high for exactly T_RPS cycles. ROWS row-only cycles follow, with `cas_n` all 1, `ras_n` low for T_RAS cycles and high for T_RP cycles between them. During the low phase of each, `ref_addr` shows 0, 1, ..., ROWS-1 in turn, and the counter wraps at ROWS so that every burst starts at row 0.
- R10: When `grant` returns after a row-only burst, the interval timer restarts with no pending refresh. No refresh starts within REFI/2 cycles, and one starts within REFI+8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_busy | input | 1 | Access path currently owns the bus |
| self_req | input | 1 | Request to enter and stay in self-refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_W | Column strobes, active low |
| we_n | output | 1 | Write enable, held high |
| ref_addr | output | ROW_W | Row address for row-only refresh |
| grant | output | 1 | Bus handed to the access path |
| ready | output | 1 | Initialisation finished |

## Verification
The hardest situation to reach is a full or saturated pending counter, because refreshes only pile up while the host keeps the bus through several interval boundaries. The stimulus locks onto an observed periodic refresh. It then raises `host_busy` half an interval later, and sweeps the hold length from one to six intervals. This makes the number of due points known exactly, and the burst that follows release must match it, capped at the counter limit. Two self-refresh visits, one shorter and one longer than the minimum hold, show that the row counter wraps at the row count rather than at its bit width.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [3:0] {
    ST_PWR,    // startup pause
    ST_CCAS,   // column strobes low ahead of row strobe
    ST_CRAS,   // row strobe low, column strobes low
    ST_CPRE,   // precharge after a column-before-row cycle
    ST_IDLE,   // bus with the access path
    ST_SCAS,   // column strobes low ahead of self-refresh entry
    ST_SHOLD,  // self-refresh hold
    ST_SEXIT,  // recovery after self-refresh exit
    ST_RLO,    // row-only refresh, row strobe low
    ST_RPRE    // row-only refresh precharge
  } seq_state_e;

endpackage

// File: rtl/dram_rfsh_phase_tmr.sv
module dram_rfsh_phase_tmr #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= W'(RST_VAL);
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dram_rfsh_interval.sv
module dram_rfsh_interval #(
  parameter int REFI   = 3900,
  parameter int PEND_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              take,
  output logic              tick,
  output logic              pend_nz,
  output logic [PEND_W-1:0] pend_cnt
);

  localparam int CW = (REFI > 1) ? $clog2(REFI) : 1;

  logic [CW-1:0]     cnt_q;
  logic [PEND_W-1:0] pend_q;

  assign tick = run && (cnt_q == CW'(REFI - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pend_q <= '0;
    end else begin
      case ({tick, take})
        2'b10:   if (!(&pend_q)) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign pend_nz  = (pend_q != '0);
  assign pend_cnt = pend_q;

endmodule

// File: rtl/dram_rfsh_rowctr.sv
module dram_rfsh_rowctr #(
  parameter int ROWS  = 8192,
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [ROW_W-1:0] row
);

  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst)                             row_q <= '0;
    else if (step && row_q == ROW_W'(ROWS - 1)) row_q <= '0;
    else if (step)                       row_q <= row_q + 1'b1;
  end

  assign row = row_q;

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int CAS_W     = 8,
  parameter int ROW_W     = 13,
  parameter int ROWS      = 8192,
  parameter int INIT_CYC  = 50000,
  parameter int WAKE_CNT  = 8,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 13,
  parameter int T_RP      = 8,
  parameter int REFI_NORM = 3900,
  parameter int REFI_LP   = 7812,
  parameter bit LOW_POWER = 1'b0,
  parameter int T_SELF    = 25000,
  parameter int T_RPS     = 25,
  parameter int PEND_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_busy,
  input  logic             self_req,
  output logic             ras_n,
  output logic [CAS_W-1:0] cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] ref_addr,
  output logic             grant,
  output logic             ready
);

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int REFI    = LOW_POWER ? REFI_LP : REFI_NORM;
  localparam int TMR_MAX = max2(max2(max2(INIT_CYC, T_SELF), max2(T_RAS, T_RP)),
                                max2(T_CSR, T_RPS));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int WAKE_W  = $clog2(WAKE_CNT + 1);

  seq_state_e        state_q, state_d;
  logic [TMR_W-1:0]  load_val;
  logic              tmr_zero, tmr_load;
  logic [WAKE_W-1:0] wake_q;
  logic              wake_inc, set_ready, ready_q;
  logic              pend_take, pend_nz, tick, iv_run;
  logic [PEND_W-1:0] pend_cnt;
  logic              row_step;
  logic [ROW_W-1:0]  row;
  logic              ras_n_q, cas_lo_q, grant_q;

  dram_rfsh_phase_tmr #(.W(TMR_W), .RST_VAL(INIT_CYC - 1)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(load_val), .zero(tmr_zero)
  );

  dram_rfsh_interval #(.REFI(REFI), .PEND_W(PEND_W)) u_interval (
    .clk(clk), .rst(rst), .run(iv_run), .take(pend_take),
    .tick(tick), .pend_nz(pend_nz), .pend_cnt(pend_cnt)
  );

  dram_rfsh_rowctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rowctr (
    .clk(clk), .rst(rst), .step(row_step), .row(row)
  );

  // interval timer runs only in normal operation; self-refresh and its
  // catch-up burst restore every row, so the timer restarts afterwards
  assign iv_run = ready_q && (state_q inside {ST_IDLE, ST_CCAS, ST_CRAS, ST_CPRE});

  always_comb begin
    state_d   = state_q;
    pend_take = 1'b0;
    row_step  = 1'b0;
    wake_inc  = 1'b0;
    set_ready = 1'b0;
    case (state_q)
      ST_PWR:   if (tmr_zero) state_d = ST_CCAS;
      ST_CCAS:  if (tmr_zero) state_d = ST_CRAS;
      ST_CRAS:  if (tmr_zero) state_d = ST_CPRE;
      ST_CPRE: begin
        if (tmr_zero) begin
          if (!ready_q) begin
            wake_inc = 1'b1;
            if (wake_q == WAKE_W'(WAKE_CNT - 1)) begin
              state_d   = ST_IDLE;
              set_ready = 1'b1;
            end else begin
              state_d = ST_CCAS;
            end
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (!host_busy) begin
          if (self_req) begin
            state_d = ST_SCAS;
          end else if (pend_nz) begin
            state_d   = ST_CCAS;
            pend_take = 1'b1;
          end
        end
      end
      ST_SCAS:  if (tmr_zero) state_d = ST_SHOLD;
      ST_SHOLD: if (tmr_zero && !self_req) state_d = ST_SEXIT;
      ST_SEXIT: if (tmr_zero) state_d = ST_RLO;
      ST_RLO: begin
        if (tmr_zero) begin
          state_d  = ST_RPRE;
          row_step = 1'b1;
        end
      end
      ST_RPRE:  if (tmr_zero) state_d = (row == '0) ? ST_IDLE : ST_RLO;
      default:  state_d = ST_PWR;
    endcase
  end

  assign tmr_load = (state_d != state_q);

  always_comb begin
    case (state_d)
      ST_CCAS, ST_SCAS: load_val = TMR_W'(T_CSR - 1);
      ST_CRAS, ST_RLO:  load_val = TMR_W'(T_RAS - 1);
      ST_CPRE, ST_RPRE: load_val = TMR_W'(T_RP - 1);
      ST_SHOLD:         load_val = TMR_W'(T_SELF - 1);
      ST_SEXIT:         load_val = TMR_W'(T_RPS - 1);
      ST_PWR:           load_val = TMR_W'(INIT_CYC - 1);
      default:          load_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_PWR;
      wake_q   <= '0;
      ready_q  <= 1'b0;
      ras_n_q  <= 1'b1;
      cas_lo_q <= 1'b0;
      grant_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (wake_inc) wake_q <= wake_q + 1'b1;
      if (set_ready) ready_q <= 1'b1;
      ras_n_q  <= !(state_d inside {ST_CRAS, ST_SHOLD, ST_RLO});
      cas_lo_q <= (state_d inside {ST_CCAS, ST_CRAS, ST_SCAS, ST_SHOLD});
      grant_q  <= (state_d == ST_IDLE);
    end
  end

  assign ras_n    = ras_n_q;
  assign cas_n    = {CAS_W{!cas_lo_q}};
  assign we_n     = 1'b1;
  assign ref_addr = row;
  assign grant    = grant_q;
  assign ready    = ready_q;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int CAS_W  = 8,
  parameter int PEND_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              host_busy,
  input logic              ras_n,
  input logic [CAS_W-1:0]  cas_n,
  input logic              grant,
  input logic              ready,
  input logic              tick,
  input logic              pend_take,
  input logic [PEND_W-1:0] pend_cnt
);

  p_cas_together_r3: assert property (@(posedge clk) disable iff (rst)
    ($countones(cas_n) == 0) || ($countones(cas_n) == CAS_W));

  p_cas_before_ras_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && cas_n == '0) |-> ($past(cas_n) == '0));

  p_busy_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    host_busy |-> (ras_n && (&cas_n)));

  p_grant_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    grant |-> (ras_n && (&cas_n) && ready));

  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    ((&pend_cnt) && tick && !pend_take && !grant) |=> (&pend_cnt));

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.CAS_W(CAS_W), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst(rst), .host_busy(host_busy), .ras_n(ras_n), .cas_n(cas_n),
  .grant(grant), .ready(ready), .tick(tick), .pend_take(pend_take),
  .pend_cnt(pend_cnt)
);

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;

  localparam int CAS_W     = 8;
  localparam int ROW_W     = 3;
  localparam int ROWS      = 6;
  localparam int INIT_CYC  = 20;
  localparam int WAKE_CNT  = 8;
  localparam int T_CSR     = 2;
  localparam int T_RAS     = 4;
  localparam int T_RP      = 3;
  localparam int REFI_NORM = 100;
  localparam int REFI_LP   = 64;
  localparam bit LOW_POWER = 1'b1;
  localparam int T_SELF    = 30;
  localparam int T_RPS     = 5;
  localparam int PEND_W    = 2;
  localparam int REFI      = LOW_POWER ? REFI_LP : REFI_NORM;
  localparam int PMAX      = (1 << PEND_W) - 1;

  logic clk = 1'b0, rst = 1'b1, host_busy = 1'b0, self_req = 1'b0;
  logic ras_n, we_n, grant, ready;
  logic [CAS_W-1:0] cas_n;
  logic [ROW_W-1:0] ref_addr;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .CAS_W(CAS_W), .ROW_W(ROW_W), .ROWS(ROWS), .INIT_CYC(INIT_CYC),
    .WAKE_CNT(WAKE_CNT), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP),
    .REFI_NORM(REFI_NORM), .REFI_LP(REFI_LP), .LOW_POWER(LOW_POWER),
    .T_SELF(T_SELF), .T_RPS(T_RPS), .PEND_W(PEND_W)
  ) u_dram_refresh_seq (
    .clk(clk), .rst(rst), .host_busy(host_busy), .self_req(self_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ref_addr(ref_addr),
    .grant(grant), .ready(ready)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // ---------------- strobe monitor ----------------
  int  cyc = 0, init_hi = 0, n_cbr = 0, n_ror = 0, last_cbr_cyc = 0;
  int  ras_hi_run = 0, ras_lo_run = 0, cas_lead = 0, sr_len = 0, exp_row = 0;
  int  cas_mixed = 0, we_low = 0, grant_early = 0, busy_falls = 0;
  bit  prev_ras = 1'b1, init_seen = 1'b0, ready_seen = 1'b0;
  bit  fall_cbr = 1'b0, after_self = 1'b0, self_mode = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      bit all_lo, all_hi;
      cyc++;
      all_lo = (cas_n == '0);
      all_hi = (&cas_n);
      if (!all_lo && !all_hi) cas_mixed++;
      if (!we_n) we_low++;
      if (!ready && grant) grant_early++;
      if (!init_seen) begin
        if (ras_n && all_hi) init_hi++;
        else begin
          init_seen = 1'b1;
          chk(init_hi == INIT_CYC, "R2", "startup pause length", init_hi, INIT_CYC);
        end
      end
      if (ready && !ready_seen) begin
        ready_seen = 1'b1;
        chk(n_cbr == WAKE_CNT, "R2", "wake-up cycles before ready", n_cbr, WAKE_CNT);
      end
      if (prev_ras && !ras_n) begin
        if (host_busy) busy_falls++;
        fall_cbr = all_lo;
        if (all_lo) begin
          n_cbr++;
          last_cbr_cyc = cyc;
          chk(cas_lead == T_CSR, "R3", "column lead", cas_lead, T_CSR);
          chk(ras_hi_run >= T_CSR + T_RP, "R3", "row high before fall", ras_hi_run, T_CSR + T_RP);
        end else begin
          n_ror++;
          chk(int'(ref_addr) == exp_row, "R9", "row-only address", ref_addr, exp_row);
          exp_row = (exp_row + 1) % ROWS;
          chk(ras_hi_run == (after_self ? T_RPS : T_RP), "R9", "row high before row-only",
              ras_hi_run, after_self ? T_RPS : T_RP);
          after_self = 1'b0;
        end
        ras_lo_run = 1;
      end else if (!prev_ras && ras_n) begin
        if (fall_cbr) begin
          chk(all_hi, "R3", "column rise with row rise", cas_n, {CAS_W{1'b1}});
          if (self_mode) begin
            sr_len = ras_lo_run;
            after_self = 1'b1;
          end else begin
            chk(ras_lo_run == T_RAS, "R3", "row low length", ras_lo_run, T_RAS);
          end
        end else begin
          chk(ras_lo_run == T_RAS, "R9", "row-only low length", ras_lo_run, T_RAS);
        end
        ras_hi_run = 1;
      end else if (ras_n) begin
        ras_hi_run++;
      end else begin
        ras_lo_run++;
      end
      if (ras_n && all_lo) cas_lead++;
      else if (ras_n) cas_lead = 0;
      prev_ras = ras_n;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_fall(output int f);
    int n0 = n_cbr;
    while (n_cbr == n0) step();
    f = last_cbr_cyc;
  endtask

  task automatic self_visit(input int hold, input bit long_hold);
    int f, r0, g, n0, ghits;
    wait_fall(f);
    while (cyc < f + REFI / 2) step();
    chk(grant == 1'b1, "R8", "grant before self request", grant, 1);
    r0 = n_ror;
    ghits = 0;
    self_mode = 1'b1;
    self_req = 1'b1;
    repeat (hold) step();
    self_req = 1'b0;
    while (n_ror < r0 + ROWS) begin
      if (grant) ghits++;
      step();
    end
    while (!grant) step();
    chk(ghits == 0, "R6", "grant during self-refresh", ghits, 0);
    if (long_hold)
      chk(sr_len > T_SELF && sr_len <= hold, "R8", "self hold follows request", sr_len, hold - 2);
    else
      chk(sr_len == T_SELF, "R8", "self hold minimum", sr_len, T_SELF);
    self_mode = 1'b0;
    g = cyc;
    n0 = n_cbr;
    repeat (REFI / 2) step();
    chk(n_cbr == n0, "R10", "no early refresh after burst", n_cbr - n0, 0);
    while (n_cbr == n0 && cyc < g + REFI + 8) step();
    chk(n_cbr == n0 + 1, "R10", "refresh after timer restart", n_cbr - n0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int f0, f1, fa, fb;
    repeat (3) @(posedge clk);
    step();
    chk(ras_n == 1'b1, "R1", "ras_n in reset", ras_n, 1);
    chk(&cas_n, "R1", "cas_n in reset", cas_n, {CAS_W{1'b1}});
    chk(we_n == 1'b1, "R1", "we_n in reset", we_n, 1);
    chk(ready == 1'b0, "R1", "ready in reset", ready, 0);
    chk(grant == 1'b0, "R1", "grant in reset", grant, 0);
    @(posedge clk);
    #1 rst = 1'b0;

    while (!ready_seen) step();

    // R5: periodic spacing with the host idle
    wait_fall(f0);
    for (int i = 0; i < 3; i++) begin
      wait_fall(f1);
      chk(f1 - f0 == REFI, "R5", "refresh spacing", f1 - f0, REFI);
      f0 = f1;
    end

    // R6 / R7: sweep host hold length over 1..6 intervals
    for (int k = 1; k <= 6; k++) begin
      int b0, c0, exp_n;
      wait_fall(fa);
      while (cyc < fa + REFI / 2) step();
      chk(grant == 1'b1, "R6", "grant before host access", grant, 1);
      host_busy = 1'b1;
      b0 = n_cbr + n_ror;
      repeat (k * REFI) step();
      chk(n_cbr + n_ror == b0, "R6", "cycles during host access", n_cbr + n_ror - b0, 0);
      host_busy = 1'b0;
      c0 = n_cbr;
      repeat (REFI / 2 - 4) step();
      exp_n = (k < PMAX) ? k : PMAX;
      chk(n_cbr - c0 == exp_n, "R7", "pending refreshes issued", n_cbr - c0, exp_n);
    end
    fb = 0;

    // R8 / R9 / R10: short and long self-refresh visits
    self_visit(5, 1'b0);
    self_visit(50, 1'b1);

    chk(we_low == 0, "R4", "samples with we_n low", we_low, 0);
    chk(cas_mixed == 0, "R3", "samples with split column strobes", cas_mixed, 0);
    chk(grant_early == 0, "R2", "grant before ready", grant_early, 0);
    chk(busy_falls == 0, "R6", "row falls while busy", busy_falls, fb);
    finish_run();
  end

endmodule